// File: doc/BRIEF.md
# Float32 to Int32 Converter

This block turns one IEEE-754 single-precision operand into a signed 32-bit two's-complement integer. It aligns the significand against the binary point, rounds away the fraction bits under one of four rounding modes, and checks that the rounded value fits in the integer range. The result is driven one clock after the operand is presented when the output register is enabled (the default). It can also be built as a pure combinational path.

The rounding mode normally comes from a global 2-bit control field. A per-operation 2-bit field with its own enable bit replaces the global field for that conversion only. Values that cannot be represented produce the fixed indefinite integer 0x80000000 and raise the invalid flag. These are NaNs, infinities, and finite values whose rounded magnitude falls outside the signed range. The invalid-mask input does not change the returned value. Trapping on the flag is left to the logic around the block.

Top module: `f2i_convert`

## Requirements
- R1: While `rst` is high, and on the clock edge at which it is sampled, `int_out` is 0 and both flags are 0.
- R2: With the default output register, the result and flags for an operand appear on the outputs after the first rising edge following its presentation. An operand that is already an integer inside the range converts exactly with both flags 0.
- R3: Rounding-mode code 2'b00 rounds to nearest, with ties going to the even integer.
- R4: Rounding-mode code 2'b01 rounds toward negative infinity.
- R5: Rounding-mode code 2'b10 rounds toward positive infinity.
- R6: Rounding-mode code 2'b11 truncates toward zero.
- R7: When `rc_embed_en` is 1, `rc_embed` selects the mode and `rc_global` is ignored. When it is 0, `rc_global` selects the mode.
- R8: NaN inputs (exponent field all ones, fraction nonzero, quiet or signalling) and both infinities set `flag_invalid`, clear `flag_inexact` and return 0x80000000.
- R9: An input whose rounded value is 2^31 or more, or below -2^31, sets `flag_invalid` and returns 0x80000000. An input equal to exactly -2^31 returns 0x80000000 with `flag_invalid` clear.
- R10: `flag_inexact` is 1 exactly when the result is valid and nonzero fraction bits were discarded. It is never 1 together with `flag_invalid`.
- R11: Zeros of either sign, and denormals, convert to 0. Under directed rounding a nonzero denormal converts to +1 or -1 when its direction requires it. Nonzero denormals set `flag_inexact`.
- R12: `inv_masked` has no effect: the result and both flags are the same for either value of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_in | input | 32 | Single-precision operand (sign bit 31, exponent 30:23, fraction 22:0) |
| rc_global | input | 2 | Global rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| rc_embed | input | 2 | Per-operation rounding mode, same encoding |
| rc_embed_en | input | 1 | 1 selects `rc_embed` over `rc_global` |
| inv_masked | input | 1 | Invalid-exception mask; does not alter the outputs |
| int_out | output | 32 | Signed integer result |
| flag_invalid | output | 1 | Input not representable as a signed 32-bit integer |
| flag_inexact | output | 1 | Valid result lost fraction bits |

## Verification
The bench builds the block with its defaults: output register on, a 32-bit integer and an 8/23 exponent/fraction split. This means every check samples one clock after it drives, and the checker's delayed copies of the inputs are active. That split puts every interesting boundary within reach of directed operands. These boundaries are the largest float below 2^31, exactly -2^31, the first exponent that overflows, the smallest denormal, and the half-way point 0.5. The registered build also lets the reset state be seen on the outputs while the inputs carry a NaN.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int FP_W    = 1 + EXP_W + FRAC_W;
    localparam int INT_W   = 32;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int MANT_W  = FRAC_W + 1;
    // exponent whose unit weight equals 2^(INT_W-1)
    localparam int EXP_LIMIT = BIAS + INT_W - 1;
    // exponent whose unit weight equals 0.5; anything below never rounds up by half
    localparam int EXP_HALF  = BIAS - 1;
    localparam int SHIFT_W   = $clog2(INT_W);
    // fixed-point window: (INT_W-1) integer bits above MANT_W fraction bits
    localparam int ALIGN_W   = MANT_W + INT_W - 1;
    localparam int MAG_W     = INT_W - 1;

    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_DOWN      = 2'b01,
        RM_UP        = 2'b10,
        RM_ZERO      = 2'b11
    } rmode_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;       // truncated integer magnitude
        logic             rnd;       // first discarded bit
        logic             sticky;    // OR of the rest
        logic             ovf;       // certainly out of range (incl. NaN/Inf)
        logic             exact_min; // magnitude exactly 2^(INT_W-1)
    } aligned_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } result_t;

    function automatic logic round_incr(rmode_e mode, logic sign, logic lsb,
                                        logic rnd, logic sticky);
        logic lost;
        lost = rnd | sticky;
        case (mode)
            RM_NEAR_EVEN: return rnd & (sticky | lsb);
            RM_DOWN:      return sign & lost;
            RM_UP:        return ~sign & lost;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/f2i_rmode_sel.sv
module f2i_rmode_sel
    import f2i_pkg::*;
(
    input  logic [1:0] global_mode,
    input  logic [1:0] embed_mode,
    input  logic       embed_en,
    output rmode_e     mode
);
    always_comb begin
        if (embed_en) mode = rmode_e'(embed_mode);
        else          mode = rmode_e'(global_mode);
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  fp_t      op,
    output aligned_t al
);
    logic [MANT_W-1:0]  mant;
    logic [EXP_W-1:0]   sh_full;
    logic [SHIFT_W-1:0] shamt;
    logic [ALIGN_W-1:0] fixed;
    logic               tiny;
    logic               huge;
    logic               at_limit;

    always_comb begin
        mant     = {(op.exp != '0), op.frac};
        sh_full  = op.exp - EXP_W'(EXP_HALF);
        shamt    = sh_full[SHIFT_W-1:0];
        fixed    = {{(ALIGN_W-MANT_W){1'b0}}, mant} << shamt;
        tiny     = op.exp < EXP_W'(EXP_HALF);
        at_limit = op.exp == EXP_W'(EXP_LIMIT);
        huge     = (op.exp > EXP_W'(EXP_LIMIT)) || (at_limit && op.frac != '0);

        al.sign      = op.sign;
        al.ovf       = huge;
        al.exact_min = at_limit && op.frac == '0;
        if (tiny) begin
            al.mag    = '0;
            al.rnd    = 1'b0;
            al.sticky = (op.exp != '0) || (op.frac != '0);
        end else if (huge || al.exact_min) begin
            al.mag    = '0;
            al.rnd    = 1'b0;
            al.sticky = 1'b0;
        end else begin
            al.mag    = fixed[ALIGN_W-1 -: MAG_W];
            al.rnd    = fixed[MANT_W-1];
            al.sticky = |fixed[MANT_W-2:0];
        end
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  aligned_t al,
    input  rmode_e   mode,
    output result_t  res
);
    logic             inc;
    logic [INT_W-1:0] mag_r;
    logic             over;

    always_comb begin
        inc = round_incr(mode, al.sign, al.mag[0], al.rnd, al.sticky);
        if (al.exact_min) mag_r = INDEF;
        else              mag_r = {1'b0, al.mag} + {{(INT_W-1){1'b0}}, inc};
        // a magnitude of 2^(INT_W-1) is only legal with a negative sign
        over = mag_r[INT_W-1] && (!al.sign || mag_r[INT_W-2:0] != '0);

        res.invalid = al.ovf || over;
        res.inexact = (al.rnd || al.sticky) && !res.invalid;
        if (res.invalid)  res.value = INDEF;
        else if (al.sign) res.value = -mag_r;
        else              res.value = mag_r;
    end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FP_W-1:0]  fp_in,
    input  logic [1:0]       rc_global,
    input  logic [1:0]       rc_embed,
    input  logic             rc_embed_en,
    input  logic             inv_masked,
    output logic [INT_W-1:0] int_out,
    output logic             flag_invalid,
    output logic             flag_inexact
);
    rmode_e   mode;
    aligned_t al;
    result_t  res;
    result_t  res_q;

    // the mask only matters to the trap logic outside this block
    logic unused_mask;
    assign unused_mask = inv_masked;

    f2i_rmode_sel u_rsel (
        .global_mode (rc_global),
        .embed_mode  (rc_embed),
        .embed_en    (rc_embed_en),
        .mode        (mode)
    );

    f2i_align u_align (
        .op (fp_t'(fp_in)),
        .al (al)
    );

    f2i_round u_round (
        .al   (al),
        .mode (mode),
        .res  (res)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res;
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign res_q = res;
        end
    endgenerate

    assign int_out      = res_q.value;
    assign flag_invalid = res_q.invalid;
    assign flag_inexact = res_q.inexact;
endmodule

// File: rtl/f2i_checker.sv
module f2i_checker
    import f2i_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [FP_W-1:0]  fp_in,
    input logic [1:0]       rc_global,
    input logic [1:0]       rc_embed,
    input logic             rc_embed_en,
    input logic [INT_W-1:0] int_out,
    input logic             flag_invalid,
    input logic             flag_inexact
);
    logic [FP_W-1:0] op_d;
    logic [1:0]      mode_d;
    logic            armed;

    generate
        if (OUT_REG) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    op_d   <= '0;
                    mode_d <= '0;
                    armed  <= 1'b0;
                end else begin
                    op_d   <= fp_in;
                    mode_d <= rc_embed_en ? rc_embed : rc_global;
                    armed  <= 1'b1;
                end
            end
        end else begin : g_now
            assign op_d   = fp_in;
            assign mode_d = rc_embed_en ? rc_embed : rc_global;
            assign armed  = 1'b1;
        end
    endgenerate

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (int_out == '0 && !flag_invalid && !flag_inexact));

    // R8
    nan_inf_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && op_d[FP_W-2 -: EXP_W] == '1) |-> (flag_invalid && int_out == INDEF));

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(flag_invalid && flag_inexact));

    // R9
    indef_chk: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> int_out == INDEF);

    // R11
    tiny_trunc_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && op_d[FP_W-2 -: EXP_W] == '0 && mode_d == 2'b11)
        |-> (int_out == '0 && !flag_invalid));

    // R2
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !flag_invalid && int_out != '0) |-> int_out[INT_W-1] == op_d[FP_W-1]);
endmodule

bind f2i_convert f2i_checker #(.OUT_REG(OUT_REG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fp_in        (fp_in),
    .rc_global    (rc_global),
    .rc_embed     (rc_embed),
    .rc_embed_en  (rc_embed_en),
    .int_out      (int_out),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
);

// File: tb/tb_f2i_convert.sv
`timescale 1ns/100ps
module tb_f2i_convert;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fp_in = 32'h7FC0_0000;
    logic [1:0]  rc_global = 2'b00;
    logic [1:0]  rc_embed = 2'b00;
    logic        rc_embed_en = 1'b0;
    logic        inv_masked = 1'b1;
    logic [31:0] int_out;
    logic        flag_invalid;
    logic        flag_inexact;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    f2i_convert dut (
        .clk(clk), .rst(rst), .fp_in(fp_in), .rc_global(rc_global),
        .rc_embed(rc_embed), .rc_embed_en(rc_embed_en), .inv_masked(inv_masked),
        .int_out(int_out), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    task automatic compare(string req, logic [31:0] ev, logic ei, logic ex);
        n_chk++;
        if (int_out !== ev || flag_invalid !== ei || flag_inexact !== ex) begin
            n_fail++;
            $display("FAIL %s: got %h inv=%b inx=%b, expected %h inv=%b inx=%b",
                     req, int_out, flag_invalid, flag_inexact, ev, ei, ex);
        end
    endtask

    // drive away from the edge, then sample one clock later
    task automatic conv(string req, logic [31:0] op, logic [1:0] g, logic [1:0] e,
                        logic en, logic msk, logic [31:0] ev, logic ei, logic ex);
        @(negedge clk);
        fp_in = op; rc_global = g; rc_embed = e; rc_embed_en = en; inv_masked = msk;
        @(negedge clk);
        compare(req, ev, ei, ex);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1", 32'h0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_exact();
        conv("R2", 32'h3F80_0000, 2'b00, 2'b00, 1'b0, 1'b1, 32'h0000_0001, 1'b0, 1'b0);
        conv("R2", 32'hC0A0_0000, 2'b01, 2'b00, 1'b0, 1'b1, 32'hFFFF_FFFB, 1'b0, 1'b0);
        conv("R2", 32'h42C8_0000, 2'b10, 2'b00, 1'b0, 1'b1, 32'h0000_0064, 1'b0, 1'b0);
        conv("R2", 32'h4B00_0001, 2'b11, 2'b00, 1'b0, 1'b1, 32'h0080_0001, 1'b0, 1'b0);
    endtask

    task automatic t_near();
        conv("R3", 32'h4020_0000, 2'b00, 2'b11, 1'b0, 1'b1, 32'h0000_0002, 1'b0, 1'b1);
        conv("R3", 32'h4060_0000, 2'b00, 2'b11, 1'b0, 1'b1, 32'h0000_0004, 1'b0, 1'b1);
        conv("R3", 32'hC020_0000, 2'b00, 2'b11, 1'b0, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b1);
        conv("R3", 32'h3FC0_0000, 2'b00, 2'b11, 1'b0, 1'b1, 32'h0000_0002, 1'b0, 1'b1);
        conv("R3", 32'h3F00_0000, 2'b00, 2'b11, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1);
        conv("R3", 32'h4030_0000, 2'b00, 2'b11, 1'b0, 1'b1, 32'h0000_0003, 1'b0, 1'b1);
    endtask

    task automatic t_down();
        conv("R4", 32'h4020_0000, 2'b01, 2'b00, 1'b0, 1'b1, 32'h0000_0002, 1'b0, 1'b1);
        conv("R4", 32'hC020_0000, 2'b01, 2'b00, 1'b0, 1'b1, 32'hFFFF_FFFD, 1'b0, 1'b1);
        conv("R4", 32'h3FA0_0000, 2'b01, 2'b00, 1'b0, 1'b1, 32'h0000_0001, 1'b0, 1'b1);
    endtask

    task automatic t_up();
        conv("R5", 32'h4020_0000, 2'b10, 2'b00, 1'b0, 1'b1, 32'h0000_0003, 1'b0, 1'b1);
        conv("R5", 32'hC020_0000, 2'b10, 2'b00, 1'b0, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b1);
        conv("R5", 32'h3E80_0000, 2'b10, 2'b00, 1'b0, 1'b1, 32'h0000_0001, 1'b0, 1'b1);
    endtask

    task automatic t_zero();
        conv("R6", 32'hC020_0000, 2'b11, 2'b00, 1'b0, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b1);
        conv("R6", 32'h4030_0000, 2'b11, 2'b00, 1'b0, 1'b1, 32'h0000_0002, 1'b0, 1'b1);
    endtask

    task automatic t_override();
        conv("R7", 32'h4010_0000, 2'b00, 2'b10, 1'b1, 1'b1, 32'h0000_0003, 1'b0, 1'b1);
        conv("R7", 32'h4010_0000, 2'b00, 2'b10, 1'b0, 1'b1, 32'h0000_0002, 1'b0, 1'b1);
        conv("R7", 32'hC030_0000, 2'b01, 2'b11, 1'b1, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b1);
    endtask

    task automatic t_special();
        conv("R8", 32'h7FC0_0000, 2'b00, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        conv("R8", 32'h7F80_0001, 2'b10, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        conv("R8", 32'h7F80_0000, 2'b11, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        conv("R8", 32'hFF80_0000, 2'b01, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_range();
        conv("R9", 32'h4F00_0000, 2'b00, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        conv("R9", 32'h4EFF_FFFF, 2'b10, 2'b00, 1'b0, 1'b1, 32'h7FFF_FF80, 1'b0, 1'b0);
        conv("R9", 32'hCF00_0000, 2'b00, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0);
        conv("R9", 32'hCF00_0001, 2'b11, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        conv("R9", 32'hCEFF_FFFF, 2'b01, 2'b00, 1'b0, 1'b1, 32'h8000_0080, 1'b0, 1'b0);
        conv("R9", 32'h5000_0000, 2'b11, 2'b00, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_tiny();
        conv("R11", 32'h0000_0000, 2'b10, 2'b00, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0);
        conv("R11", 32'h8000_0000, 2'b01, 2'b00, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0);
        conv("R11", 32'h0000_0001, 2'b00, 2'b00, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1);
        conv("R11", 32'h0000_0001, 2'b10, 2'b00, 1'b0, 1'b1, 32'h0000_0001, 1'b0, 1'b1);
        conv("R11", 32'h8000_0001, 2'b01, 2'b00, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1);
        conv("R11", 32'h8000_0001, 2'b11, 2'b00, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b1);
        // R10: denormal with rounding up away from it still inexact, never invalid
        conv("R10", 32'h007F_FFFF, 2'b10, 2'b00, 1'b0, 1'b1, 32'h0000_0001, 1'b0, 1'b1);
    endtask

    task automatic t_mask();
        conv("R12", 32'h7FC0_0000, 2'b00, 2'b00, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0);
        conv("R12", 32'h4F80_0000, 2'b00, 2'b00, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0);
        conv("R12", 32'h4020_0000, 2'b00, 2'b00, 1'b0, 1'b0, 32'h0000_0002, 1'b0, 1'b1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_exact();
        t_near();
        t_down();
        t_up();
        t_zero();
        t_override();
        t_special();
        t_range();
        t_tiny();
        t_mask();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
    end
endmodule